// File: doc/BRIEF.md
# Host-to-DSP Mailbox with Gated Status Interrupt

This block is the register window between a host microcontroller bus and an embedded signal-processing core. The host sees seven 16-bit registers at even byte addresses: clock control, command, status, hardware configuration, a DSP-to-host data word, a host-to-DSP data word and an interrupt enable mask. The DSP side presents a status-update port and a data-load port. It receives the clock-control, configuration, host-to-DSP data and command values as plain outputs, and the command comes with a one-cycle strobe.

Bit 0 of the status word is the ready flag. When the host issues the read-request command, the ready flag clears. The flag sets again when the DSP loads a new data word. A level interrupt goes to the host when an enabled status bit changes. After it fires, the interrupt logic is disarmed until the host writes the acknowledge command. The request drops only when an acknowledge is followed by a status read. A ready-flag change that comes with a wake-up qualifier does not count as an event.

Top module: `dspmb_top`

## Requirements
- R1: Register byte offsets are clock control 0x0, command 0x2, status 0x4, configuration 0x6, DSP-to-host data 0x8, host-to-DSP data 0xA, mask 0xC. Every register resets to 0x0000, and `host_irq` is low out of reset.
- R2: Clock control, configuration, host-to-DSP data and mask are written by the host and read back. The first three drive `dsp_clkctl`, `dsp_cfg` and `dsp_h2d`. Read data appears on `host_rdata` in the cycle after `host_rd`.
- R3: Host writes to status, to DSP-to-host data, to odd addresses and to 0xE change nothing.
- R4: A command write stores the word on `dsp_cmd` and raises `dsp_cmd_stb` for exactly the one cycle after the write.
- R5: Command 0x0001 clears status bit 0. This host-caused clear never raises the interrupt.
- R6: A DSP data load stores the word and sets status bit 0. It takes priority over a read-request command in the same cycle.
- R7: A host read of DSP-to-host data returns 0x0000 while status bit 0 is 0.
- R8: A status update replaces the status word. If any bit whose mask bit is 1 changes while the logic is armed, `host_irq` goes high after that same clock edge. A data load that sets bit 0 counts as a change.
- R9: Changes confined to bits whose mask bit is 0 never raise the interrupt.
- R10: With the wake qualifier set, a change on bit 0 is ignored, but changes on other enabled bits still raise the interrupt.
- R11: After the interrupt rises, further events are ignored until command 0x0002 (acknowledge) is written. Other command values do not re-arm.
- R12: The interrupt drops only on a status read that follows an acknowledge. A status read alone leaves it high, and a second acknowledge adds nothing.
- R13: An enabled event between the acknowledge and the status read cancels that acknowledge. A fresh acknowledge and read are then needed.
- R14: After reset the logic is armed, so the first enabled event raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| host_irq | output | 1 | Level interrupt to the host |
| dsp_stat_vld | input | 1 | Status update valid |
| dsp_stat_word | input | 16 | New status word |
| dsp_stat_wake | input | 1 | Update caused by a wake-up from power-down |
| dsp_data_vld | input | 1 | Data load valid |
| dsp_data_word | input | 16 | Word for the DSP-to-host register |
| dsp_clkctl | output | 16 | Clock-control register value |
| dsp_cfg | output | 16 | Configuration register value |
| dsp_h2d | output | 16 | Host-to-DSP data value |
| dsp_cmd | output | 16 | Last command written |
| dsp_cmd_stb | output | 1 | One-cycle pulse after a command write |

## Verification
Some properties are checked on every cycle. The interrupt falls only in the cycle after a status read, and it rises only after a detected event. A read-request clears the ready flag unless a load coincides. A load sets the flag and stores its word. The command strobe follows a command write, and a gated data read returns zero. Other behaviour shows only in the bench's sequences: mask filtering, the bit-0-only wake exclusion, staying disarmed until acknowledge, the ignored second acknowledge, an event that cancels a pending acknowledge, and re-arming after a mid-run reset.

// File: rtl/dspmb_pkg.sv
package dspmb_pkg;

    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned RDY_BIT  = 0;
    localparam int unsigned CMD_RDREQ = 1;
    localparam int unsigned CMD_ACK   = 2;

    typedef enum logic [2:0] {
        SEL_CLK  = 3'd0,
        SEL_CMD  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_CFG  = 3'd3,
        SEL_D2H  = 3'd4,
        SEL_H2D  = 3'd5,
        SEL_MASK = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } host_acc_t;

    localparam logic [ADDR_W-1:0] ADDR_CMD  = ADDR_W'(2 * int'(SEL_CMD));
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(2 * int'(SEL_STAT));
    localparam logic [ADDR_W-1:0] ADDR_D2H  = ADDR_W'(2 * int'(SEL_D2H));

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a[0] || a[ADDR_W-1:1] == 3'd7)
            return SEL_NONE;
        return reg_sel_e'(a[ADDR_W-1:1]);
    endfunction

endpackage

// File: rtl/dspmb_hostregs.sv
module dspmb_hostregs
    import dspmb_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  host_acc_t     acc,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] stat_q,
    input  logic [DW-1:0] d2h_q,
    output logic [DW-1:0] clkctl_q,
    output logic [DW-1:0] cfg_q,
    output logic [DW-1:0] h2d_q,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] cmd_q,
    output logic          cmd_stb,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] rd_mux;

    always_comb begin
        case (acc.sel)
            SEL_CLK:  rd_mux = clkctl_q;
            SEL_CMD:  rd_mux = cmd_q;
            SEL_STAT: rd_mux = stat_q;
            SEL_CFG:  rd_mux = cfg_q;
            SEL_D2H:  rd_mux = stat_q[RDY_BIT] ? d2h_q : '0;
            SEL_H2D:  rd_mux = h2d_q;
            SEL_MASK: rd_mux = mask_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clkctl_q <= '0;
            cfg_q    <= '0;
            h2d_q    <= '0;
            mask_q   <= '0;
            cmd_q    <= '0;
            cmd_stb  <= 1'b0;
            rdata    <= '0;
        end else begin
            cmd_stb <= 1'b0;
            if (acc.wr) begin
                case (acc.sel)
                    SEL_CLK:  clkctl_q <= wdata;
                    SEL_CMD: begin
                        cmd_q   <= wdata;
                        cmd_stb <= 1'b1;
                    end
                    SEL_CFG:  cfg_q  <= wdata;
                    SEL_H2D:  h2d_q  <= wdata;
                    SEL_MASK: mask_q <= wdata;
                    default: ;
                endcase
            end
            if (acc.rd)
                rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/dspmb_status.sv
module dspmb_status
    import dspmb_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stat_vld,
    input  logic [DW-1:0] stat_word,
    input  logic          stat_wake,
    input  logic          data_vld,
    input  logic [DW-1:0] data_word,
    input  logic          rdy_clr,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] d2h_q,
    output logic          event_o
);

    logic [DW-1:0] dsp_nxt;
    logic [DW-1:0] stat_d;
    logic [DW-1:0] ev_bits;
    logic          wake_excl;

    assign wake_excl = stat_vld && stat_wake;

    always_comb begin
        dsp_nxt = stat_vld ? stat_word : stat_q;
        if (data_vld)
            dsp_nxt[RDY_BIT] = 1'b1;
        stat_d = dsp_nxt;
        if (rdy_clr && !data_vld)
            stat_d[RDY_BIT] = 1'b0;
    end

    for (genvar b = 0; b < DW; b++) begin : g_chg
        if (b == RDY_BIT) begin : g_rdy
            assign ev_bits[b] = (dsp_nxt[b] ^ stat_q[b]) && mask[b] && !wake_excl;
        end else begin : g_oth
            assign ev_bits[b] = (dsp_nxt[b] ^ stat_q[b]) && mask[b];
        end
    end

    assign event_o = |ev_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            d2h_q  <= '0;
        end else begin
            stat_q <= stat_d;
            if (data_vld)
                d2h_q <= data_word;
        end
    end

endmodule

// File: rtl/dspmb_irq.sv
module dspmb_irq (
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic ack_i,
    input  logic stat_rd_i,
    output logic irq_o
);

    logic armed;
    logic ackd;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            armed <= 1'b1;
            ackd  <= 1'b0;
        end else if (event_i && armed) begin
            irq_o <= 1'b1;
            armed <= 1'b0;
            ackd  <= 1'b0;
        end else begin
            if (ack_i && irq_o && !armed) begin
                armed <= 1'b1;
                ackd  <= 1'b1;
            end
            if (stat_rd_i && ackd) begin
                irq_o <= 1'b0;
                ackd  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dspmb_top.sv
module dspmb_top
    import dspmb_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_irq,
    input  logic              dsp_stat_vld,
    input  logic [DW-1:0]     dsp_stat_word,
    input  logic              dsp_stat_wake,
    input  logic              dsp_data_vld,
    input  logic [DW-1:0]     dsp_data_word,
    output logic [DW-1:0]     dsp_clkctl,
    output logic [DW-1:0]     dsp_cfg,
    output logic [DW-1:0]     dsp_h2d,
    output logic [DW-1:0]     dsp_cmd,
    output logic              dsp_cmd_stb
);

    host_acc_t     acc;
    logic          cmd_wr;
    logic          rdy_clr;
    logic          ack;
    logic          stat_rd;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] d2h_q;
    logic          stat_event;

    assign acc.wr  = host_wr;
    assign acc.rd  = host_rd;
    assign acc.sel = decode_addr(host_addr);

    assign cmd_wr  = host_wr && (acc.sel == SEL_CMD);
    assign rdy_clr = cmd_wr && (host_wdata == DW'(CMD_RDREQ));
    assign ack     = cmd_wr && (host_wdata == DW'(CMD_ACK));
    assign stat_rd = host_rd && (acc.sel == SEL_STAT);

    dspmb_hostregs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .wdata    (host_wdata),
        .stat_q   (stat_q),
        .d2h_q    (d2h_q),
        .clkctl_q (dsp_clkctl),
        .cfg_q    (dsp_cfg),
        .h2d_q    (dsp_h2d),
        .mask_q   (mask_q),
        .cmd_q    (dsp_cmd),
        .cmd_stb  (dsp_cmd_stb),
        .rdata    (host_rdata)
    );

    dspmb_status #(.DW(DW)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .stat_vld  (dsp_stat_vld),
        .stat_word (dsp_stat_word),
        .stat_wake (dsp_stat_wake),
        .data_vld  (dsp_data_vld),
        .data_word (dsp_data_word),
        .rdy_clr   (rdy_clr),
        .mask      (mask_q),
        .stat_q    (stat_q),
        .d2h_q     (d2h_q),
        .event_o   (stat_event)
    );

    dspmb_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .event_i   (stat_event),
        .ack_i     (ack),
        .stat_rd_i (stat_rd),
        .irq_o     (host_irq)
    );

endmodule

// File: rtl/dspmb_chk.sv
module dspmb_chk
    import dspmb_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DW-1:0]     host_wdata,
    input logic [DW-1:0]     host_rdata,
    input logic              host_irq,
    input logic              dsp_data_vld,
    input logic [DW-1:0]     dsp_data_word,
    input logic              dsp_cmd_stb,
    input logic [DW-1:0]     stat_q,
    input logic [DW-1:0]     d2h_q,
    input logic              ev
);

    assert_irq_drop_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(host_irq) |-> $past(host_rd && host_addr == ADDR_STAT));

    assert_irq_rise_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(host_irq) |-> $past(ev));

    assert_rdy_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $past(host_wr && host_addr == ADDR_CMD && host_wdata == DW'(CMD_RDREQ) && !dsp_data_vld)
        |-> !stat_q[RDY_BIT]);

    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        $past(dsp_data_vld) |-> (stat_q[RDY_BIT] && d2h_q == $past(dsp_data_word)));

    assert_cmd_stb_R4: assert property (@(posedge clk) disable iff (rst)
        dsp_cmd_stb |-> $past(host_wr && host_addr == ADDR_CMD));

    assert_d2h_gate_R7: assert property (@(posedge clk) disable iff (rst)
        $past(host_rd && host_addr == ADDR_D2H && !stat_q[RDY_BIT]) |-> host_rdata == '0);

endmodule

bind dspmb_top dspmb_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_addr     (host_addr),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .host_irq      (host_irq),
    .dsp_data_vld  (dsp_data_vld),
    .dsp_data_word (dsp_data_word),
    .dsp_cmd_stb   (dsp_cmd_stb),
    .stat_q        (stat_q),
    .d2h_q         (d2h_q),
    .ev            (stat_event)
);

// File: tb/sim_dspmb_top.sv
module sim_dspmb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_irq;
    logic        dsp_stat_vld = 1'b0;
    logic [15:0] dsp_stat_word = '0;
    logic        dsp_stat_wake = 1'b0;
    logic        dsp_data_vld = 1'b0;
    logic [15:0] dsp_data_word = '0;
    logic [15:0] dsp_clkctl, dsp_cfg, dsp_h2d, dsp_cmd;
    logic        dsp_cmd_stb;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_CLK = 4'h0, A_CMD = 4'h2, A_STAT = 4'h4, A_CFG = 4'h6,
                           A_D2H = 4'h8, A_H2D = 4'hA, A_MASK = 4'hC;

    always #5 clk = ~clk;

    dspmb_top u0 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .dsp_stat_vld(dsp_stat_vld), .dsp_stat_word(dsp_stat_word), .dsp_stat_wake(dsp_stat_wake),
        .dsp_data_vld(dsp_data_vld), .dsp_data_word(dsp_data_word),
        .dsp_clkctl(dsp_clkctl), .dsp_cfg(dsp_cfg), .dsp_h2d(dsp_h2d),
        .dsp_cmd(dsp_cmd), .dsp_cmd_stb(dsp_cmd_stb)
    );

    // {mask, status word, wake, expected irq}
    localparam logic [33:0] VEC [10] = '{
        {16'hFFFF, 16'h0004, 1'b0, 1'b1},  // R8 plain change
        {16'hFFFF, 16'h0004, 1'b0, 1'b0},  // R8 no change
        {16'h0004, 16'h0008, 1'b0, 1'b1},  // R9 enabled bit among changes
        {16'h0004, 16'h0018, 1'b0, 1'b0},  // R9 only masked-off bit
        {16'hFFFF, 16'h0019, 1'b1, 1'b0},  // R10 bit0 rise on wake
        {16'hFFFF, 16'h0018, 1'b1, 1'b0},  // R10 bit0 fall on wake
        {16'hFFFF, 16'h0019, 1'b0, 1'b1},  // R10 bit0 rise without wake
        {16'h0001, 16'h0119, 1'b1, 1'b0},  // R9 bit8 masked off
        {16'h0100, 16'h0019, 1'b1, 1'b1},  // R10 wake spares other bits
        {16'h0000, 16'h0000, 1'b0, 1'b0}   // R9 mask all off
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic stat_upd(input logic [15:0] w, input logic wk);
        @(negedge clk);
        dsp_stat_word = w; dsp_stat_wake = wk; dsp_stat_vld = 1'b1;
        @(negedge clk);
        dsp_stat_vld = 1'b0; dsp_stat_wake = 1'b0;
    endtask

    task automatic data_load(input logic [15:0] w);
        @(negedge clk);
        dsp_data_word = w; dsp_data_vld = 1'b1;
        @(negedge clk);
        dsp_data_vld = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq after reset", {15'd0, host_irq}, 16'h0000);
        for (int a = 0; a < 14; a += 2) begin
            rd_reg(4'(a), rv);
            chk("R1 register reset value", rv, 16'h0000);
        end

        // Table walk: mask, update, irq, then acknowledge + status read
        for (int i = 0; i < 10; i++) begin
            wr_reg(A_MASK, VEC[i][33:18]);
            stat_upd(VEC[i][17:2], VEC[i][1]);
            chk(i == 0 ? "R14 first event raises R8" : "R8 R9 R10 table irq",
                {15'd0, host_irq}, {15'd0, VEC[i][0]});
            wr_reg(A_CMD, 16'h0002);
            rd_reg(A_STAT, rv);
            chk("R8 status word", rv, VEC[i][17:2]);
            chk("R12 irq cleared after ack and read", {15'd0, host_irq}, 16'h0000);
        end

        // R2 read/write registers
        wr_reg(A_CLK, 16'h1234);
        wr_reg(A_CFG, 16'h00A5);
        wr_reg(A_H2D, 16'hCAFE);
        rd_reg(A_CLK, rv); chk("R2 clkctl readback", rv, 16'h1234);
        rd_reg(A_CFG, rv); chk("R2 cfg readback", rv, 16'h00A5);
        rd_reg(A_H2D, rv); chk("R2 h2d readback", rv, 16'hCAFE);
        chk("R2 clkctl out", dsp_clkctl, 16'h1234);
        chk("R2 cfg out", dsp_cfg, 16'h00A5);
        chk("R2 h2d out", dsp_h2d, 16'hCAFE);

        // R3 ignored writes
        wr_reg(A_STAT, 16'hFFFF);
        rd_reg(A_STAT, rv); chk("R3 status write ignored", rv, 16'h0000);
        wr_reg(4'h1, 16'hFFFF);
        wr_reg(4'hE, 16'hFFFF);
        rd_reg(A_CLK, rv); chk("R3 odd/unmapped write ignored", rv, 16'h1234);

        // R7 gated read, R6 load
        rd_reg(A_D2H, rv); chk("R7 d2h reads zero while not ready", rv, 16'h0000);
        data_load(16'hBEEF);
        rd_reg(A_STAT, rv); chk("R6 load sets ready", rv, 16'h0001);
        rd_reg(A_D2H, rv); chk("R6 load stores word", rv, 16'hBEEF);
        wr_reg(A_D2H, 16'h5555);
        rd_reg(A_D2H, rv); chk("R3 d2h write ignored", rv, 16'hBEEF);

        // R4 command strobe, R5 read-request clears ready without irq
        wr_reg(A_MASK, 16'hFFFF);
        @(negedge clk);
        host_addr = A_CMD; host_wdata = 16'h0001; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R4 strobe after command write", {15'd0, dsp_cmd_stb}, 16'h0001);
        chk("R4 command value", dsp_cmd, 16'h0001);
        @(negedge clk);
        chk("R4 strobe single cycle", {15'd0, dsp_cmd_stb}, 16'h0000);
        chk("R5 host clear raises no irq", {15'd0, host_irq}, 16'h0000);
        rd_reg(A_STAT, rv); chk("R5 ready cleared", rv, 16'h0000);
        rd_reg(A_D2H, rv); chk("R7 d2h gated after clear", rv, 16'h0000);

        // R6 priority: read-request and load in the same cycle
        @(negedge clk);
        host_addr = A_CMD; host_wdata = 16'h0001; host_wr = 1'b1;
        dsp_data_word = 16'h1234; dsp_data_vld = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; dsp_data_vld = 1'b0;
        chk("R8 load setting ready raises irq", {15'd0, host_irq}, 16'h0001);
        rd_reg(A_STAT, rv); chk("R6 load wins over clear", rv, 16'h0001);
        chk("R12 read without ack keeps irq", {15'd0, host_irq}, 16'h0001);
        rd_reg(A_D2H, rv); chk("R6 same-cycle word", rv, 16'h1234);

        // R11 disarmed; other command does not re-arm
        stat_upd(16'h0011, 1'b0);
        wr_reg(A_CMD, 16'h0004);
        rd_reg(A_STAT, rv);
        chk("R11 non-ack command does not clear", {15'd0, host_irq}, 16'h0001);
        wr_reg(A_CMD, 16'h0002);
        wr_reg(A_CMD, 16'h0002);
        chk("R12 irq held until status read", {15'd0, host_irq}, 16'h0001);
        rd_reg(A_STAT, rv);
        chk("R12 second ack harmless, read clears", {15'd0, host_irq}, 16'h0000);
        chk("R11 event while disarmed lost", {15'd0, host_irq}, 16'h0000);

        // R13 event between ack and read
        stat_upd(16'h0010, 1'b0);
        chk("R13 irq raised", {15'd0, host_irq}, 16'h0001);
        wr_reg(A_CMD, 16'h0002);
        stat_upd(16'h0030, 1'b0);
        rd_reg(A_STAT, rv);
        chk("R13 pending ack cancelled", {15'd0, host_irq}, 16'h0001);
        wr_reg(A_CMD, 16'h0002);
        rd_reg(A_STAT, rv);
        chk("R13 fresh ack and read clear", {15'd0, host_irq}, 16'h0000);

        // R14 mid-run reset re-arms
        stat_upd(16'h0000, 1'b0);
        chk("R14 irq before reset", {15'd0, host_irq}, 16'h0001);
        do_reset();
        chk("R14 irq low after reset", {15'd0, host_irq}, 16'h0000);
        rd_reg(A_CLK, rv); chk("R1 clkctl reset again", rv, 16'h0000);
        wr_reg(A_MASK, 16'hFFFF);
        stat_upd(16'h0002, 1'b0);
        chk("R14 armed after reset", {15'd0, host_irq}, 16'h0001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule